// File: doc/BRIEF.md
# Transceiver Channel Control Register Bank

This block holds the byte-wide control registers for four transceiver lanes. Each lane has one register with four live control bits: a test-pattern enable, a lane-wide alarm master mask, a sticky software reset and a test-mode enable. Software reaches the registers through a simple synchronous port. A write takes effect at the clock edge where `wr_en` is high. A read returns its data on `rd_data` one cycle after `rd_en`.

The stored bits drive per-lane outputs. One output enables both the lane's pattern generator and its pattern checker. One is the lane's datapath reset. One is the lane's test-mode line, which a global test input can force high. The block also ORs the transmit and receive alarms of every lane into one registered interrupt. Each alarm first passes its own mask input and then the lane's master mask bit, and the master mask wins.

There is no sequencing state, so the block has no state machine. Its only storage is the four lane registers, the read-data register and the interrupt register.

Top module: `serdes_ctl_bank`

## Requirements
- R1: A synchronous active-high `rst` sets every lane register to 0x02 and clears `rd_data` and `irq` to 0. While `rst` is high, every bit of `lane_rst` is 1.
- R2: Lane n (n = 0 to 3) is at byte address 0x30104 + 0x10·n. A write changes only the lane whose address matches.
- R3: Inside each register, bit 0 is the pattern enable, bit 1 is the master mask, bit 2 is the software reset and bit 3 is the test enable. Bits 7..4 always read as 0, and writing them has no effect.
- R4: `pat_gen_en[n]` and `pat_chk_en[n]` both equal bit 0 of lane n's register.
- R5: `irq` in cycle k+1 is the OR over lanes of the lane's contribution in cycle k. A lane contributes when ((`tx_alarm` AND NOT `tx_alarm_mask`) OR (`rx_alarm` AND NOT `rx_alarm_mask`)) is true and its master mask bit is 0.
- R6: While lane n's master mask bit is 1, lane n's alarms never raise `irq`, whatever its individual mask inputs are.
- R7: `lane_rst[n]` is 1 while bit 2 of lane n is 1. The bit stays set until software writes 0 to it. While it is set, the other bits of that lane keep their values and stay readable.
- R8: `test_mode[n]` equals bit 3 of lane n when `glob_test` is 0. All four bits are 1 when `glob_test` is 1.
- R9: A read of an address that matches no lane returns 0x00. A write to such an address changes no register.
- R10: Read data appears one cycle after `rd_en`. A read and a write to the same lane in the same cycle return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 20 | Byte address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid one cycle after `rd_en` |
| glob_test | input | 1 | Global test enable |
| tx_alarm | input | 4 | Transmit alarm per lane |
| rx_alarm | input | 4 | Receive alarm per lane |
| tx_alarm_mask | input | 4 | Individual transmit alarm mask per lane |
| rx_alarm_mask | input | 4 | Individual receive alarm mask per lane |
| pat_gen_en | output | 4 | Pattern generator enable per lane |
| pat_chk_en | output | 4 | Pattern checker enable per lane |
| lane_rst | output | 4 | Datapath reset per lane |
| test_mode | output | 4 | Test mode per lane |
| irq | output | 1 | Registered, masked alarm interrupt |

## Verification
The functions that can meet in one cycle are a register read and a register write. The bench raises `rd_en` and `wr_en` together on the same lane address. The scoreboard expects the value held before the write, and a second read must then return the new contents.

A second overlap is a write that clears a lane's master mask in the same cycle as a pending alarm. The bench checks that `irq` is still 0 one cycle later, because the mask was set when the interrupt register sampled it. It then checks that `irq` rises one cycle after that.

// File: rtl/serdes_ctl_pkg.sv
package serdes_ctl_pkg;
    localparam int LANES      = 4;
    localparam int ADDR_W     = 20;
    localparam int DATA_W     = 8;
    localparam logic [ADDR_W-1:0] BASE_ADDR   = 20'h30104;
    localparam logic [ADDR_W-1:0] LANE_STRIDE = 20'h00010;

    // Field layout of one lane register; reserved bits at the top.
    typedef struct packed {
        logic [3:0] rsvd;
        logic       test_en;
        logic       sw_rst;
        logic       mmask;
        logic       pat_en;
    } lane_cfg_t;

    localparam lane_cfg_t CFG_RESET = '{rsvd: 4'h0, test_en: 1'b0, sw_rst: 1'b0,
                                        mmask: 1'b1, pat_en: 1'b0};
    localparam logic [DATA_W-1:0] LIVE_BITS = 8'h0F;

    function automatic logic [ADDR_W-1:0] lane_addr(input int n);
        return BASE_ADDR + LANE_STRIDE * n;
    endfunction
endpackage

// File: rtl/sctl_lane_reg.sv
module sctl_lane_reg
    import serdes_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [DATA_W-1:0] wr_data,
    output lane_cfg_t         cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= CFG_RESET;
        else if (wr_hit)
            cfg_q <= lane_cfg_t'(wr_data & LIVE_BITS);
    end

    // R2: without an address hit the register does not move
    p_wr_only_hit_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(cfg_q));

    // R7: software reset is sticky until written
    p_swrst_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.sw_rst && !wr_hit) |=> cfg_q.sw_rst);
endmodule

// File: rtl/sctl_irq_gate.sv
module sctl_irq_gate
    import serdes_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] tx_alarm,
    input  logic [LANES-1:0] rx_alarm,
    input  logic [LANES-1:0] tx_alarm_mask,
    input  logic [LANES-1:0] rx_alarm_mask,
    input  logic [LANES-1:0] master_mask,
    output logic             irq
);
    logic [LANES-1:0] lane_hit;

    always_comb begin
        lane_hit = ((tx_alarm & ~tx_alarm_mask) | (rx_alarm & ~rx_alarm_mask))
                   & ~master_mask;
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq <= 1'b0;
        else
            irq <= |lane_hit;
    end

    // R6: alarms only on master-masked lanes never raise the interrupt
    p_mask_block_r6: assert property (@(posedge clk) disable iff (rst)
        (((tx_alarm | rx_alarm) & ~master_mask) == '0) |=> !irq);
endmodule

// File: rtl/serdes_ctl_bank.sv
module serdes_ctl_bank
    import serdes_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              glob_test,
    input  logic [LANES-1:0]  tx_alarm,
    input  logic [LANES-1:0]  rx_alarm,
    input  logic [LANES-1:0]  tx_alarm_mask,
    input  logic [LANES-1:0]  rx_alarm_mask,
    output logic [LANES-1:0]  pat_gen_en,
    output logic [LANES-1:0]  pat_chk_en,
    output logic [LANES-1:0]  lane_rst,
    output logic [LANES-1:0]  test_mode,
    output logic              irq
);
    lane_cfg_t        cfg [LANES];
    logic [LANES-1:0] hit;
    logic [LANES-1:0] mmask;
    logic [LANES-1:0] swrst;
    logic [LANES-1:0] tsten;
    logic [LANES-1:0] paten;

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        assign hit[n]   = (addr == lane_addr(n));
        assign mmask[n] = cfg[n].mmask;
        assign swrst[n] = cfg[n].sw_rst;
        assign tsten[n] = cfg[n].test_en;
        assign paten[n] = cfg[n].pat_en;

        sctl_lane_reg u_reg (
            .clk     (clk),
            .rst     (rst),
            .wr_hit  (wr_en && hit[n]),
            .wr_data (wr_data),
            .cfg_q   (cfg[n])
        );
    end

    // Read path: registered mux, unmapped addresses return zero
    logic [DATA_W-1:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        for (int n = 0; n < LANES; n++)
            if (hit[n]) rd_mux = cfg[n];
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else
            rd_data <= rd_en ? rd_mux : '0;
    end

    assign pat_gen_en = paten;
    assign pat_chk_en = paten;
    assign lane_rst   = {LANES{rst}} | swrst;
    assign test_mode  = tsten | {LANES{glob_test}};

    sctl_irq_gate u_irq (
        .clk           (clk),
        .rst           (rst),
        .tx_alarm      (tx_alarm),
        .rx_alarm      (rx_alarm),
        .tx_alarm_mask (tx_alarm_mask),
        .rx_alarm_mask (rx_alarm_mask),
        .master_mask   (mmask),
        .irq           (irq)
    );

    // R9: a read that hits no lane returns zero
    p_unmapped_rd_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && hit == '0) |=> (rd_data == '0));

    // R8: global test forces every lane into test mode
    p_glob_test_r8: assert property (@(posedge clk) disable iff (rst)
        glob_test |-> (&test_mode));

    // R3: reserved bits never read back as one
    p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> (rd_data[7:4] == 4'h0));
endmodule

// File: tb/serdes_ctl_bank_bench.sv
module serdes_ctl_bank_bench;
    logic        clk = 1'b0;
    logic        rst, wr_en, rd_en, glob_test;
    logic [19:0] addr;
    logic [7:0]  wr_data, rd_data;
    logic [3:0]  tx_alarm, rx_alarm, tx_alarm_mask, rx_alarm_mask;
    logic [3:0]  pat_gen_en, pat_chk_en, lane_rst, test_mode;
    logic        irq;

    int total = 0;
    int bad   = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] model [4];
    logic       rd_seen = 1'b0;

    always #5 clk = ~clk;

    serdes_ctl_bank u_serdes_ctl_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .glob_test(glob_test),
        .tx_alarm(tx_alarm), .rx_alarm(rx_alarm),
        .tx_alarm_mask(tx_alarm_mask), .rx_alarm_mask(rx_alarm_mask),
        .pat_gen_en(pat_gen_en), .pat_chk_en(pat_chk_en),
        .lane_rst(lane_rst), .test_mode(test_mode), .irq(irq)
    );

    function automatic logic [19:0] la(input int n);
        return 20'h30104 + 20'h10 * n;
    endfunction

    function automatic int lane_of(input logic [19:0] a);
        for (int n = 0; n < 4; n++) if (a == la(n)) return n;
        return -1;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver: one access cycle, read expectation pushed to scoreboard
    task automatic access(input logic w, input logic r, input logic [19:0] a,
                          input logic [7:0] d, input string req);
        int ln;
        ln = lane_of(a);
        wr_en = w; rd_en = r; addr = a; wr_data = d;
        if (r) begin
            exp_q.push_back(ln >= 0 ? model[ln] : 8'h00);
            tag_q.push_back(req);
        end
        if (w && ln >= 0) model[ln] = d & 8'h0F;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    // Monitor: compare read data one cycle after the strobe
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) check("R10 unexpected read", 1, 0);
            else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    task automatic hw_reset();
        rst = 1'b1;
        @(negedge clk);
        check("R1 lane_rst during reset", lane_rst, 4'hF);
        rst = 1'b0;
        for (int n = 0; n < 4; n++) model[n] = 8'h02;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 0; rd_en = 0; addr = '0; wr_data = '0; glob_test = 0;
        tx_alarm = 0; rx_alarm = 0; tx_alarm_mask = 0; rx_alarm_mask = 0;
        @(negedge clk);
        hw_reset();

        // R1 reset state
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 irq", irq, 0);
        check("R1 pattern enables", {pat_gen_en, pat_chk_en}, 8'h00);
        check("R1 test_mode", test_mode, 4'h0);
        check("R1 lane_rst", lane_rst, 4'h0);
        for (int n = 0; n < 4; n++) access(0, 1, la(n), 0, "R1 R2 reset readback");

        // R3 reserved bits, R4 pattern, R7 sw reset, R8 test enable
        access(1, 0, la(1), 8'hFF, "R3");
        access(0, 1, la(1), 0, "R3 reserved bits read zero");
        check("R4 gen", pat_gen_en, 4'b0010);
        check("R4 chk", pat_chk_en, 4'b0010);
        check("R7 lane_rst set", lane_rst, 4'b0010);
        check("R8 test_mode lane", test_mode, 4'b0010);
        for (int n = 0; n < 4; n++) access(0, 1, la(n), 0, "R2 only lane 1 changed");

        // R7 sticky reset with configuration kept
        access(1, 0, la(2), 8'h05, "R7");
        repeat (5) @(negedge clk);
        check("R7 sticky", lane_rst, 4'b0110);
        check("R7 config kept", pat_gen_en, 4'b0110);
        access(0, 1, la(2), 0, "R7 readback");
        access(1, 0, la(2), 8'h01, "R7");
        check("R7 cleared", lane_rst, 4'b0010);
        check("R7 pattern kept after clear", pat_chk_en, 4'b0110);

        // R9 unmapped read and write
        access(0, 1, 20'h30108, 0, "R9 unmapped read");
        access(1, 0, 20'h30144, 8'hFF, "R9");
        access(1, 0, 20'h30100, 8'hFF, "R9");
        for (int n = 0; n < 4; n++) access(0, 1, la(n), 0, "R9 no change");

        // R8 global test
        glob_test = 1'b1; #1;
        check("R8 global forces", test_mode, 4'hF);
        glob_test = 1'b0; #1;
        check("R8 global off", test_mode, 4'b0010);

        // R6 master mask override
        tx_alarm = 4'b1001; rx_alarm = 4'b1001;
        repeat (3) @(negedge clk);
        check("R6 masked lanes quiet", irq, 0);

        // R5/R6 clear lane 0 master mask: mask still set when sampled
        access(1, 0, la(0), 8'h00, "R5");
        check("R5 irq one cycle late", irq, 0);
        @(negedge clk);
        check("R5 irq raised", irq, 1);
        tx_alarm_mask = 4'b0001; #1;
        check("R5 irq not yet dropped", irq, 1);
        @(negedge clk);
        check("R5 rx path holds irq", irq, 1);
        rx_alarm_mask = 4'b0001;
        @(negedge clk);
        check("R5 individual masks", irq, 0);
        rx_alarm_mask = 4'b0000; tx_alarm = 4'b0000; rx_alarm = 4'b0001;
        @(negedge clk);
        check("R5 rx alarm alone", irq, 1);
        access(1, 0, la(0), 8'h02, "R6");
        @(negedge clk);
        check("R6 master mask again", irq, 0);
        rx_alarm = 0; tx_alarm_mask = 0;

        // R10 collision: read returns old value
        access(1, 1, la(3), 8'h08, "R10 read-during-write old value");
        access(0, 1, la(3), 0, "R10 new value");

        // R1 reset mid-run
        hw_reset();
        for (int n = 0; n < 4; n++) access(0, 1, la(n), 0, "R1 reset restores 0x02");
        @(negedge clk);
        check("R10 scoreboard drained", exp_q.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule